// File: doc/BRIEF.md
# Burst-of-Two Double-Data-Rate Synchronous SRAM

This block is a synthesizable behavioural model of a synchronous SRAM with a double-data-rate interface and a burst length of two. It uses two clocks: a true clock `k_clk` and its complement `kn_clk`. Each address selects a location that holds an even word and an odd word. A read or a write command moves both words in one clock cycle, one word on each clock edge. Commands are sampled only on rising edges of `k_clk`. Because a burst needs a whole cycle of transfers, at most one command is taken in any two consecutive cycles.

The shared data pins are modelled as an input bus `wr_d`, an output bus `rd_q` and an output enable `q_oe`. A mode input `lat_long` selects the read latency. When it is high, read data starts two cycles after the command. When it is low, read data starts after one cycle. The valid flag `q_vld` and the echo clocks follow the read data half-cycle by half-cycle, so a receiver can capture `rd_q` without using the input clocks. A write is held in a posted register for one cycle before it reaches the array. A read of that address in the meantime is served from the posted register.

Top module: `ddrb2_sram`

## Requirements
- R1: While `rst_n` is low, `q_vld`, `q_oe` and `rd_q` are all zero.
- R2: With `lat_long` high, a read sampled at rising `k_clk` edge n drives the even word from rising `k_clk` edge n+2 until the next rising `kn_clk` edge. It then drives the odd word until edge n+3.
- R3: With `lat_long` low, the same burst is driven one cycle earlier: the even word from edge n+1 and the odd word from the following rising `kn_clk` edge.
- R4: For a write sampled at `k_clk` edge n, the even word is taken from `wr_d` at the next rising `kn_clk` edge and the odd word at `k_clk` edge n+1. A later read of that address returns the even word first and then the odd word.
- R5: `q_vld` is high in exactly the half-cycles that carry read data. It is low in all other half-cycles, including those that follow write commands.
- R6: A command whose load is high on the `k_clk` edge right after an accepted command is ignored. An ignored read produces no data. An ignored write leaves the array unchanged.
- R7: A read sampled two cycles after a write to the same address (the earliest allowed) returns the newly written words.
- R8: `echo_k` is high from each rising `k_clk` edge to the next rising `kn_clk` edge and low for the other half-cycle. `echo_kn` is always its complement.
- R9: `q_oe` is high only in read data half-cycles, and `rd_q` is zero whenever `q_oe` is low.
- R10: A cycle with `cmd_ld` low samples no command, and the corresponding output slots stay invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| k_clk | input | 1 | True clock; commands and odd write words are sampled on its rising edge |
| kn_clk | input | 1 | Complementary clock; even write words are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the control and output state |
| lat_long | input | 1 | 1 = two-cycle read latency, 0 = one-cycle read latency |
| cmd_ld | input | 1 | Load strobe, active high |
| cmd_rd | input | 1 | 1 = read, 0 = write |
| addr | input | ADDR_W | Location address |
| wr_d | input | WORD_W | Write data, one word per clock edge |
| rd_q | output | WORD_W | Read data, one word per half-cycle, zero when not driving |
| q_oe | output | 1 | Output enable of the shared data pins |
| q_vld | output | 1 | Read data valid |
| echo_k | output | 1 | Echo clock in phase with the even-word half-cycles |
| echo_kn | output | 1 | Complement of `echo_k` |

## Verification
Take a read sampled at `k_clk` edge n. Its even word is due in the half-cycle after edge n+2 when the mode input is high, and after edge n+1 when it is low. The odd word follows in the next half-cycle. Write data is due one half-cycle and one full cycle after the command. The bench counts half-cycle slots. Whenever it accepts a read, it files the expected words and a valid flag into the slot that lies that many edges ahead. Every slot is compared 2 ns after the edge that opens it, well before the next edge. The same slot table covers the invalid slots that follow idle cycles, ignored loads and writes, and the echo clock level in each slot.

// File: rtl/ddrb2_pkg.sv
`timescale 1ns/1ps
package ddrb2_pkg;

   typedef enum logic {
      LAT_SHORT = 1'b0,
      LAT_LONG  = 1'b1
   } lat_mode_e;

   function automatic bit word_width_ok(input int w);
      return (w == 8) || (w == 9) || (w == 18) || (w == 36);
   endfunction

endpackage

// File: rtl/ddrb2_cmd.sv
`timescale 1ns/1ps
module ddrb2_cmd #(
   parameter int ADDR_W = 6
) (
   input  logic              k_clk,
   input  logic              rst_n,
   input  logic              cmd_ld,
   input  logic              cmd_rd,
   input  logic [ADDR_W-1:0] addr,
   output logic              rd_go,
   output logic              wr_go,
   output logic              wr_arm,
   output logic [ADDR_W-1:0] wr_addr
);

   logic busy;

   // A burst fills a whole cycle, so the edge after an accepted command is blocked
   assign rd_go = cmd_ld &  cmd_rd & ~busy;
   assign wr_go = cmd_ld & ~cmd_rd & ~busy;

   always_ff @(posedge k_clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         wr_arm  <= 1'b0;
         wr_addr <= '0;
      end else begin
         busy   <= rd_go | wr_go;
         wr_arm <= wr_go;
         if (wr_go) wr_addr <= addr;
      end
   end

endmodule

// File: rtl/ddrb2_store.sv
`timescale 1ns/1ps
module ddrb2_store #(
   parameter int WORD_W = 18,
   parameter int ADDR_W = 6
) (
   input  logic              k_clk,
   input  logic              kn_clk,
   input  logic              rst_n,
   input  logic              wr_arm,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [WORD_W-1:0] wr_d,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [WORD_W-1:0] rd_w0,
   output logic [WORD_W-1:0] rd_w1,
   output logic              pend_v
);

   localparam int DEPTH = 1 << ADDR_W;
   localparam int LANES = 2;

   logic [WORD_W-1:0] even_hold;
   logic [ADDR_W-1:0] pend_addr;
   logic [WORD_W-1:0] pend_w [LANES];
   logic [WORD_W-1:0] lane_q [LANES];
   logic              hit;

   // Even word arrives on the complementary edge after the command
   always_ff @(posedge kn_clk or negedge rst_n) begin
      if (!rst_n)      even_hold <= '0;
      else if (wr_arm) even_hold <= wr_d;
   end

   // Posted write: both words parked for one cycle, then committed
   always_ff @(posedge k_clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_v    <= 1'b0;
         pend_addr <= '0;
         pend_w[0] <= '0;
         pend_w[1] <= '0;
      end else begin
         pend_v <= wr_arm;
         if (wr_arm) begin
            pend_addr <= wr_addr;
            pend_w[0] <= even_hold;
            pend_w[1] <= wr_d;
         end
      end
   end

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         logic [WORD_W-1:0] cells [DEPTH];
         always_ff @(posedge k_clk) begin
            if (pend_v) cells[pend_addr] <= pend_w[g];
         end
         assign lane_q[g] = cells[rd_addr];
      end
   endgenerate

   // The array is written on the same edge a following read samples it
   assign hit   = pend_v && (pend_addr == rd_addr);
   assign rd_w0 = hit ? pend_w[0] : lane_q[0];
   assign rd_w1 = hit ? pend_w[1] : lane_q[1];

endmodule

// File: rtl/ddrb2_rdpipe.sv
`timescale 1ns/1ps
module ddrb2_rdpipe #(
   parameter int WORD_W = 18,
   parameter int LAT_HI = 2,
   parameter int LAT_LO = 1
) (
   input  logic              k_clk,
   input  logic              kn_clk,
   input  logic              rst_n,
   input  logic              lat_long,
   input  logic              rd_go,
   input  logic [WORD_W-1:0] rd_w0,
   input  logic [WORD_W-1:0] rd_w1,
   output logic [LAT_HI-1:0] stg_v,
   output logic              head_v,
   output logic [WORD_W-1:0] rd_q,
   output logic              q_oe,
   output logic              q_vld,
   output logic              echo_k,
   output logic              echo_kn
);

   localparam int SEL_HI = LAT_HI - 1;
   localparam int SEL_LO = LAT_LO - 1;

   logic [WORD_W-1:0] stg_w0 [LAT_HI];
   logic [WORD_W-1:0] stg_w1 [LAT_HI];
   logic [WORD_W-1:0] head_w0, head_w1;
   logic              tail_v;
   logic [WORD_W-1:0] tail_w;
   logic              tog_k, tog_kn, k_half, drive;
   logic [WORD_W-1:0] word_sel;

   always_ff @(posedge k_clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_v[0]  <= 1'b0;
         stg_w0[0] <= '0;
         stg_w1[0] <= '0;
      end else begin
         stg_v[0] <= rd_go;
         if (rd_go) begin
            stg_w0[0] <= rd_w0;
            stg_w1[0] <= rd_w1;
         end
      end
   end

   generate
      for (genvar i = 1; i < LAT_HI; i++) begin : g_stage
         always_ff @(posedge k_clk or negedge rst_n) begin
            if (!rst_n) begin
               stg_v[i]  <= 1'b0;
               stg_w0[i] <= '0;
               stg_w1[i] <= '0;
            end else begin
               stg_v[i]  <= stg_v[i-1];
               stg_w0[i] <= stg_w0[i-1];
               stg_w1[i] <= stg_w1[i-1];
            end
         end
      end
   endgenerate

   // Output head register: even-word slot, launched on the true clock
   always_ff @(posedge k_clk or negedge rst_n) begin
      if (!rst_n) begin
         head_v  <= 1'b0;
         head_w0 <= '0;
         head_w1 <= '0;
         tog_k   <= 1'b0;
      end else begin
         tog_k <= ~tog_k;
         if (lat_long == ddrb2_pkg::LAT_LONG) begin
            head_v  <= stg_v[SEL_HI];
            head_w0 <= stg_w0[SEL_HI];
            head_w1 <= stg_w1[SEL_HI];
         end else begin
            head_v  <= stg_v[SEL_LO];
            head_w0 <= stg_w0[SEL_LO];
            head_w1 <= stg_w1[SEL_LO];
         end
      end
   end

   // Odd-word slot, launched on the complementary clock
   always_ff @(posedge kn_clk or negedge rst_n) begin
      if (!rst_n) begin
         tail_v <= 1'b0;
         tail_w <= '0;
         tog_kn <= 1'b0;
      end else begin
         tail_v <= head_v;
         tail_w <= head_w1;
         tog_kn <= tog_k;
      end
   end

   // Toggles differ only between a true edge and the next complementary edge
   assign k_half   = tog_k ^ tog_kn;
   assign drive    = k_half ? head_v : tail_v;
   assign word_sel = k_half ? head_w0 : tail_w;
   assign rd_q     = drive ? word_sel : '0;
   assign q_vld    = drive;
   assign q_oe     = drive;
   assign echo_k   = k_half;
   assign echo_kn  = ~k_half;

endmodule

// File: rtl/ddrb2_sram.sv
`timescale 1ns/1ps
module ddrb2_sram #(
   parameter int WORD_W = 18,
   parameter int ADDR_W = 6,
   parameter int LAT_HI = 2,
   parameter int LAT_LO = 1
) (
   input  logic              k_clk,
   input  logic              kn_clk,
   input  logic              rst_n,
   input  logic              lat_long,
   input  logic              cmd_ld,
   input  logic              cmd_rd,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WORD_W-1:0] wr_d,
   output logic [WORD_W-1:0] rd_q,
   output logic              q_oe,
   output logic              q_vld,
   output logic              echo_k,
   output logic              echo_kn
);

   generate
      if (!ddrb2_pkg::word_width_ok(WORD_W)) begin : g_bad_width
         $error("ddrb2_sram: WORD_W must be 8, 9, 18 or 36");
      end
      if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
         $error("ddrb2_sram: ADDR_W out of range 1..12");
      end
      if (LAT_LO < 1 || LAT_LO > LAT_HI) begin : g_bad_lat
         $error("ddrb2_sram: need 1 <= LAT_LO <= LAT_HI");
      end
   endgenerate

   logic              rd_go, wr_go, wr_arm, pend_v, head_v;
   logic [ADDR_W-1:0] wr_addr;
   logic [WORD_W-1:0] rd_w0, rd_w1;
   logic [LAT_HI-1:0] stg_v;

   ddrb2_cmd #(.ADDR_W(ADDR_W)) u_cmd (
      .k_clk   (k_clk),
      .rst_n   (rst_n),
      .cmd_ld  (cmd_ld),
      .cmd_rd  (cmd_rd),
      .addr    (addr),
      .rd_go   (rd_go),
      .wr_go   (wr_go),
      .wr_arm  (wr_arm),
      .wr_addr (wr_addr)
   );

   ddrb2_store #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_store (
      .k_clk   (k_clk),
      .kn_clk  (kn_clk),
      .rst_n   (rst_n),
      .wr_arm  (wr_arm),
      .wr_addr (wr_addr),
      .wr_d    (wr_d),
      .rd_addr (addr),
      .rd_w0   (rd_w0),
      .rd_w1   (rd_w1),
      .pend_v  (pend_v)
   );

   ddrb2_rdpipe #(.WORD_W(WORD_W), .LAT_HI(LAT_HI), .LAT_LO(LAT_LO)) u_pipe (
      .k_clk    (k_clk),
      .kn_clk   (kn_clk),
      .rst_n    (rst_n),
      .lat_long (lat_long),
      .rd_go    (rd_go),
      .rd_w0    (rd_w0),
      .rd_w1    (rd_w1),
      .stg_v    (stg_v),
      .head_v   (head_v),
      .rd_q     (rd_q),
      .q_oe     (q_oe),
      .q_vld    (q_vld),
      .echo_k   (echo_k),
      .echo_kn  (echo_kn)
   );

endmodule

// File: rtl/ddrb2_sram_chk.sv
`timescale 1ns/1ps
module ddrb2_sram_chk #(
   parameter int LAT_HI = 2,
   parameter int LAT_LO = 1
) (
   input logic              k_clk,
   input logic              kn_clk,
   input logic              rst_n,
   input logic              lat_long,
   input logic              rd_go,
   input logic              wr_go,
   input logic              pend_v,
   input logic [LAT_HI-1:0] stg_v,
   input logic              head_v,
   input logic              echo_k,
   input logic              echo_kn
);

   a_r6_gap_after_accept: assert property (@(posedge k_clk) disable iff (!rst_n)
      (rd_go || wr_go) |=> !(rd_go || wr_go));

   a_r3_short_path: assert property (@(posedge k_clk) disable iff (!rst_n)
      (!lat_long && stg_v[LAT_LO-1]) |=> head_v);

   a_r2_long_path: assert property (@(posedge k_clk) disable iff (!rst_n)
      (lat_long && stg_v[LAT_HI-1]) |=> head_v);

   a_r5_one_burst_per_slot: assert property (@(posedge k_clk) disable iff (!rst_n)
      head_v |=> !head_v);

   a_r4_commit_once: assert property (@(posedge k_clk) disable iff (!rst_n)
      pend_v |=> !pend_v);

   a_r8_echo_high: assert property (@(posedge kn_clk) disable iff (!rst_n)
      echo_k && !echo_kn);

   a_r8_echo_low: assert property (@(posedge k_clk) disable iff (!rst_n)
      !echo_k && echo_kn);

endmodule

bind ddrb2_sram ddrb2_sram_chk #(.LAT_HI(LAT_HI), .LAT_LO(LAT_LO)) u_chk (
   .k_clk    (k_clk),
   .kn_clk   (kn_clk),
   .rst_n    (rst_n),
   .lat_long (lat_long),
   .rd_go    (rd_go),
   .wr_go    (wr_go),
   .pend_v   (pend_v),
   .stg_v    (stg_v),
   .head_v   (head_v),
   .echo_k   (echo_k),
   .echo_kn  (echo_kn)
);

// File: tb/sim_ddrb2_sram.sv
`timescale 1ns/1ps
module sim_ddrb2_sram;

   localparam int W     = 18;
   localparam int AW    = 5;
   localparam int DEPTH = 1 << AW;
   localparam int NS    = 16;

   logic          k_clk = 1'b0;
   logic          kn_clk;
   logic          rst_n = 1'b0;
   logic          lat_long = 1'b1;
   logic          cmd_ld = 1'b0, cmd_rd = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [W-1:0]  wr_d = '0;
   logic [W-1:0]  rd_q;
   logic          q_oe, q_vld, echo_k, echo_kn;

   always #4 k_clk = ~k_clk;
   assign kn_clk = ~k_clk;

   ddrb2_sram #(.WORD_W(W), .ADDR_W(AW)) u0 (
      .k_clk(k_clk), .kn_clk(kn_clk), .rst_n(rst_n), .lat_long(lat_long),
      .cmd_ld(cmd_ld), .cmd_rd(cmd_rd), .addr(addr), .wr_d(wr_d),
      .rd_q(rd_q), .q_oe(q_oe), .q_vld(q_vld), .echo_k(echo_k), .echo_kn(echo_kn)
   );

   int       n_chk = 0, n_err = 0;
   bit       done = 1'b0;
   logic [W-1:0] ref0 [DEPTH];
   logic [W-1:0] ref1 [DEPTH];
   logic         ev [NS];
   logic [W-1:0] eq [NS];
   string        er [NS];
   int           cyc = 0;
   logic         busy_b = 1'b0, wq_v = 1'b0;
   logic [W-1:0] wq0 = '0, wq1 = '0;

   function automatic logic [W-1:0] rnd_word();
      return W'($urandom);
   endfunction

   function automatic int read_delay(input logic mode);
      return mode ? 2 : 1;
   endfunction

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic check_slot(input int s, input bit even);
      int i = s % NS;
      check(er[i], "q_vld", 64'(q_vld), 64'(ev[i]));
      check("R9", "q_oe", 64'(q_oe), 64'(ev[i]));
      check(ev[i] ? er[i] : "R9", "rd_q", 64'(rd_q), 64'(eq[i]));
      check("R8", "echo_k", 64'(echo_k), 64'(even));
      check("R8", "echo_kn", 64'(echo_kn), 64'(!even));
      ev[i] = 1'b0;
      eq[i] = '0;
      er[i] = "R5";
   endtask

   // One true-clock cycle: check both slots and queue the next command
   task automatic step(input logic ld, input logic rd, input logic [AW-1:0] a,
                       input logic [W-1:0] d0, input logic [W-1:0] d1, input string tag);
      logic         prev_v;
      logic [W-1:0] prev_d1;
      logic         acc;
      int           s;
      @(posedge k_clk);
      cyc++;
      #2;
      check_slot(2*cyc, 1'b1);
      prev_v  = wq_v;
      prev_d1 = wq1;
      wr_d    = prev_v ? wq0 : rnd_word();
      cmd_ld  = ld;
      cmd_rd  = rd;
      addr    = a;
      acc     = ld && !busy_b;
      busy_b  = acc;
      wq_v    = acc && !rd;
      s = 2 * (cyc + 1 + read_delay(lat_long));
      if (acc && rd) begin
         ev[s % NS] = 1'b1;  eq[s % NS] = ref0[a];  er[s % NS] = tag;
         ev[(s+1) % NS] = 1'b1;  eq[(s+1) % NS] = ref1[a];  er[(s+1) % NS] = tag;
      end else begin
         if (!ev[s % NS]) er[s % NS] = !ld ? "R10" : (acc ? "R5" : "R6");
         if (!ev[(s+1) % NS]) er[(s+1) % NS] = !ld ? "R10" : (acc ? "R5" : "R6");
      end
      if (acc && !rd) begin
         ref0[a] = d0;  ref1[a] = d1;  wq0 = d0;  wq1 = d1;
      end
      #4;
      check_slot(2*cyc + 1, 1'b0);
      wr_d = prev_v ? prev_d1 : rnd_word();
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) step(1'b0, 1'b0, '0, '0, '0, "R10");
   endtask

   task automatic set_mode(input logic m);
      idle(4);
      lat_long = m;
   endtask

   initial begin
      repeat (150000) @(posedge k_clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL R5 watchdog: actual=running expected=finished");
         $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      for (int i = 0; i < NS; i++) begin
         ev[i] = 1'b0;  eq[i] = '0;  er[i] = "R5";
      end
      // R1: outputs quiet under reset
      #10;
      check("R1", "q_vld", 64'(q_vld), 64'd0);
      check("R1", "q_oe", 64'(q_oe), 64'd0);
      check("R1", "rd_q", 64'(rd_q), 64'd0);
      @(posedge kn_clk);
      #2 rst_n = 1'b1;

      // R4: fill every location, with idle cycles between writes
      for (int a = 0; a < DEPTH; a++) begin
         step(1'b1, 1'b0, AW'(a), rnd_word(), rnd_word(), "R4");
         idle(1);
      end
      idle(2);
      // R2: two-cycle latency read
      step(1'b1, 1'b1, AW'(3), '0, '0, "R2");
      idle(4);
      // R4: known words come back even first, odd second
      step(1'b1, 1'b0, AW'(7), W'('h15a5a), W'('h0c3c3), "R4");
      idle(3);
      step(1'b1, 1'b1, AW'(7), '0, '0, "R4");
      idle(4);
      // R7: read at the earliest edge after a write, long mode
      step(1'b1, 1'b0, AW'(9), W'('h2aaaa), W'('h15555), "R7");
      idle(1);
      step(1'b1, 1'b1, AW'(9), '0, '0, "R7");
      set_mode(1'b0);
      // R3: one-cycle latency read
      step(1'b1, 1'b1, AW'(3), '0, '0, "R3");
      idle(3);
      // R7: same-address read right after write, short mode
      step(1'b1, 1'b0, AW'(11), W'('h01234), W'('h3fedc), "R7");
      idle(1);
      step(1'b1, 1'b1, AW'(11), '0, '0, "R7");
      idle(3);
      // R6: load right after an accepted read is ignored (write, then read)
      step(1'b1, 1'b1, AW'(10), '0, '0, "R6");
      step(1'b1, 1'b0, AW'(10), W'('h3ffff), W'('h3ffff), "R6");
      idle(1);
      step(1'b1, 1'b1, AW'(10), '0, '0, "R6");
      step(1'b1, 1'b1, AW'(12), '0, '0, "R6");
      idle(4);
      // Random mixed traffic, both latency modes
      for (int m = 0; m < 2; m++) begin
         set_mode(m == 0 ? 1'b1 : 1'b0);
         for (int k = 0; k < 500; k++) begin
            step(($urandom % 10) < 7, $urandom % 2, AW'($urandom),
                 rnd_word(), rnd_word(), lat_long ? "R2" : "R3");
         end
      end
      idle(6);
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule